// File: doc/BRIEF.md
# Latched Event Interrupt Controller

This block gathers four peripheral events into one interrupt line. The events are a timer A underflow, a timer B underflow, a clock alarm and a serial byte received. Each event arrives as a one-cycle pulse and sets a sticky flag. The flag stays set whether or not its source is enabled. A separate enable mask decides which flags can pull the active-low interrupt output low.

Software changes the mask with a single byte write. The top bit of the byte chooses the action. When it is 1, the low bits that are 1 turn their sources on. When it is 0, the low bits that are 1 turn their sources off. Mask bits written as 0 keep their value in both cases. A read returns every latched flag together with a summary bit, and that same read clears all the flags together. An event that lands in the same cycle as the clearing read is kept.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, all flags and all mask bits are 0, `rd_data_o` is 0x00 and `irq_no` is 1.
- R2: Flag positions are fixed: timer A is bit 0, timer B is bit 1, the clock alarm is bit 2 and the serial byte is bit 3. A pulse on `evt_i[k]` appears as `rd_data_o[k]` = 1 in the cycle after the pulse.
- R3: A write with data bit 7 = 1 sets each mask bit k (k = 0..3) whose data bit k is 1. Mask bits written as 0 keep their value. For example, 0x8B enables bits 0, 1 and 3.
- R4: A write with data bit 7 = 0 clears each mask bit k whose data bit k is 1. Mask bits written as 0 keep their value. For example, 0x7F disables every source.
- R5: Flags latch even when their mask bit is 0. A flag whose mask bit is 0 does not pull `irq_no` low.
- R6: `irq_no` is 0 exactly when at least one flag is set and its mask bit is set.
- R7: `rd_data_o` bit 7 is 1 exactly when some enabled flag is pending. Bits 6:4 always read 0.
- R8: A read (`rd_en_i` high at a clock edge) clears all flags at once. If no event arrives in that cycle, the next cycle shows flags of 0 and `irq_no` = 1.
- R9: An event that arrives in the same cycle as a clearing read remains pending after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 4 | One-cycle event pulses (bit0 timer A, bit1 timer B, bit2 alarm, bit3 serial) |
| wr_en_i | input | 1 | Mask write strobe |
| wr_data_i | input | 8 | Mask write data; bit 7 selects set (1) or clear (0) |
| rd_en_i | input | 1 | Read strobe; clears all flags at the clock edge |
| rd_data_o | output | 8 | Flags in bits 3:0, summary in bit 7 |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
The in-design assertions check on every cycle:
- An event always leaves its flag set on the next cycle, including when a read clears the flags in that same cycle.
- A read with no incoming event leaves the flags empty and the interrupt line released.
- Set and clear writes change only the mask bits they name.
- An enabled event always pulls the line low on the next cycle.

Some behaviour only the bench's scenarios can show. Masked flags stay visible through a read without raising the interrupt. The fixed bit order and the summary bit are reported correctly. Long random mixes of events, writes and reads match an independent model of the register.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int NUM_SRC = 4;
  localparam int DATA_W  = 8;
  localparam int SRC_TMR_A  = 0;
  localparam int SRC_TMR_B  = 1;
  localparam int SRC_ALARM  = 2;
  localparam int SRC_SERIAL = 3;
endpackage

// File: rtl/evt_flag_cell.sv
module evt_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // new event wins over the clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= (flag_q & ~clr_i) | ev_i;
  end

  assign flag_o = flag_q;

  // R9
  ev_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i |=> flag_o);
  // R8
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ev_i) |=> !flag_o);
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               set_i,
  input  logic [NUM_SRC-1:0] bits_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_en_i) mask_q <= set_i ? (mask_q | bits_i) : (mask_q & ~bits_i);
  end

  assign mask_o = mask_q;

  // R3
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && set_i) |=> ((mask_o & $past(bits_i)) == $past(bits_i)) &&
                           ((mask_o & ~$past(bits_i)) == ($past(mask_o) & ~$past(bits_i))));
  // R4
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !set_i) |=> ((mask_o & $past(bits_i)) == '0) &&
                            ((mask_o & ~$past(bits_i)) == ($past(mask_o) & ~$past(bits_i))));
endmodule

// File: rtl/evt_rd_fmt.sv
module evt_rd_fmt #(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8
) (
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               pend_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  always_comb begin
    pend_o    = |(flags_i & mask_i);
    rd_data_o = '0;
    rd_data_o[NUM_SRC-1:0] = flags_i;
    rd_data_o[DATA_W-1]    = pend_o;
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int NUM_SRC = evt_irq_pkg::NUM_SRC,
  parameter int DATA_W  = evt_irq_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_no
);
  localparam int CtlBit = DATA_W - 1;

  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] mask;
  logic               pend;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
    evt_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ev_i   (evt_i[k]),
      .clr_i  (rd_en_i),
      .flag_o (flags[k])
    );
  end

  evt_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .set_i   (wr_data_i[CtlBit]),
    .bits_i  (wr_data_i[NUM_SRC-1:0]),
    .mask_o  (mask)
  );

  evt_rd_fmt #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_fmt (
    .flags_i   (flags),
    .mask_i    (mask),
    .pend_o    (pend),
    .rd_data_o (rd_data_o)
  );

  assign irq_no = ~pend;

  // R6
  irq_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(evt_i & mask)) && !wr_en_i) |=> !irq_no);
  // R8
  irq_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (evt_i == '0)) |=> irq_no);
endmodule

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] evt_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       irq_no;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [3:0] m_flags = '0;
  logic [3:0] m_mask = '0;

  always #5 clk_i = ~clk_i;

  evt_irq_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .irq_no(irq_no)
  );

  function automatic logic [7:0] exp_rd(logic [3:0] f, logic [3:0] m);
    return {|(f & m), 3'b000, f};
  endfunction

  task automatic check(string tag);
    logic [7:0] er;
    logic       ei;
    er = exp_rd(m_flags, m_mask);
    ei = ~|(m_flags & m_mask);
    n_chk++;
    if (rd_data_o !== er) begin
      n_bad++;
      $display("FAIL %s rd_data actual=%02h expected=%02h", tag, rd_data_o, er);
    end
    n_chk++;
    if (irq_no !== ei) begin
      n_bad++;
      $display("FAIL %s irq_no actual=%0b expected=%0b", tag, irq_no, ei);
    end
  endtask

  // drive one cycle at negedge, update model at posedge, check at next negedge
  task automatic cyc(logic [3:0] ev, logic we, logic [7:0] wd, logic re, string tag);
    @(negedge clk_i);
    evt_i = ev; wr_en_i = we; wr_data_i = wd; rd_en_i = re;
    @(posedge clk_i);
    m_flags = (re ? 4'h0 : m_flags) | ev;
    if (we) m_mask = wd[7] ? (m_mask | wd[3:0]) : (m_mask & ~wd[3:0]);
    @(negedge clk_i);
    evt_i = '0; wr_en_i = 1'b0; rd_en_i = 1'b0;
    #1 check(tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 reset");
    rst_ni = 1'b1;
    cyc(4'h0, 1'b1, 8'h8B, 1'b0, "R3 enable 0x8B");
    cyc(4'h4, 1'b0, 8'h00, 1'b0, "R5 masked alarm latches");
    cyc(4'h1, 1'b0, 8'h00, 1'b0, "R2 R6 R7 timer A bit0");
    cyc(4'h2, 1'b0, 8'h00, 1'b0, "R2 timer B bit1");
    cyc(4'h0, 1'b0, 8'h00, 1'b1, "R8 read clears all");
    cyc(4'h8, 1'b0, 8'h00, 1'b1, "R9 serial event during read");
    cyc(4'h0, 1'b1, 8'h7F, 1'b0, "R4 disable all 0x7F");
    cyc(4'h0, 1'b1, 8'h84, 1'b0, "R3 enable alarm only");
    cyc(4'h4, 1'b0, 8'h00, 1'b0, "R6 alarm enabled");
    cyc(4'h0, 1'b1, 8'h04, 1'b0, "R4 clear alarm bit");
    cyc(4'h0, 1'b0, 8'h00, 1'b1, "R8 read with masked flags");
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] ev;
      logic [7:0] wd;
      ev = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      wd = 8'($urandom) & 8'h8F;
      cyc(ev, ($urandom % 5 == 0), wd, ($urandom % 4 == 0), "R6 R7 R9 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule